// File: doc/BRIEF.md
# Host Port Instruction Loader

This block fills an on-chip instruction RAM from an external host or DMA controller that writes bytes into an 8-bit host port. Pairs of bytes form 16-bit words, with the low byte first. The sequencer takes each complete word as soon as it is present. Between words it does nothing else. A flag in the host status register and an active-low pin tell the host when it may start the next word.

A start request with a mode bit selects one of two loads. A full boot first reads a three-word header: a filler word, the instruction count, and a status setting. It then loads the instructions from address 0x200 and branches to 0x200. A reboot skips the header. It takes the count, the start address and the return address from the requesting program (normally in the region 0x4000 to 0xBFFF). When it finishes, it hands back the return address. Each 32-bit instruction arrives as its lower half and then its upper half. Each half is written to the RAM as it is taken.

The sequencer states are `ST_IDLE`, `ST_DUMMY`, `ST_COUNT`, `ST_STATUS`, `ST_LOWER`, `ST_UPPER` and `ST_FINISH`. Their transitions are:

- `ST_IDLE` goes to `ST_DUMMY` on a boot start. On a reboot start it goes to `ST_LOWER`, or to `ST_FINISH` if the count is zero.
- `ST_DUMMY` goes to `ST_COUNT`, and `ST_COUNT` goes to `ST_STATUS`, each on a word.
- `ST_STATUS` goes to `ST_LOWER` on a word, or to `ST_FINISH` if the count is zero.
- `ST_LOWER` goes to `ST_UPPER` on a word.
- `ST_UPPER` goes back to `ST_LOWER` on a word, or to `ST_FINISH` after the last instruction.
- `ST_FINISH` always goes to `ST_IDLE`.

Top module: `hbl_loader`

## Requirements
- R1: Two accepted host bytes form one 16-bit word: the first byte is bits 7:0 and the second is bits 15:8.
- R2: A boot (`start` with `start_mode`=0) consumes three header words in this order: filler, instruction count, status setting. The value of the filler word has no effect on any output.
- R3: When the status setting word is taken, `host_status[7:3]` takes word bits 7:3 and the write-enable bit `host_status[2]` becomes 1, whatever word bit 2 holds. A reboot leaves bits 7:2 unchanged.
- R4: Each instruction produces two RAM writes at the same address: first `iram_hi`=0 with the lower 16 bits, then `iram_hi`=1 with the upper 16 bits. `iram_we` is high for exactly one cycle per write.
- R5: A boot writes its first instruction at address 0x200. The address advances by one after each upper-half write.
- R6: At the end of a load, `done` is high for exactly one cycle. `branch_addr` is 0x200 after a boot and `ret_addr` after a reboot.
- R7: A reboot (`start_mode`=1) takes no header words. It writes `reboot_count` instructions starting at `reboot_addr`.
- R8: The ready flag `host_status[0]` is 1 and `host_rdy_n` is 0 only while the loader waits for the first byte of a word. Both deassert from the first byte until the word has been taken, and reassert one clock after the take. While idle the flag is 0.
- R9: A byte written while the port cannot accept it is ignored. This covers a byte while idle, and a byte while a complete word is still pending. The ignored byte sets the sticky overrun bit `host_status[1]`, which only reset clears.
- R10: A count of zero gives `done` with no RAM write. For a boot this happens right after the status word; for a reboot, right after the start.
- R11: A `start` while a load is running is ignored.
- R12: After reset, `host_status` is 0x00, `host_rdy_n` is 1, and `iram_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host byte write strobe, one cycle per byte |
| host_byte | input | 8 | Host byte |
| start | input | 1 | Load request |
| start_mode | input | 1 | 0 = full boot, 1 = reboot |
| reboot_count | input | 16 | Instruction count for a reboot |
| reboot_addr | input | 16 | First RAM address for a reboot |
| ret_addr | input | 16 | Branch target after a reboot |
| iram_we | output | 1 | Instruction RAM write strobe |
| iram_hi | output | 1 | 0 = lower half, 1 = upper half of the instruction |
| iram_addr | output | 16 | Instruction RAM address |
| iram_data | output | 16 | Half-instruction data |
| host_status | output | 8 | {setting[4:0], write enable, overrun, ready} |
| host_rdy_n | output | 1 | Active-low ready pin for the host |
| done | output | 1 | One-cycle completion pulse |
| branch_addr | output | 16 | Branch target, valid with done |

## Verification
Two functions can fall in the same cycle: the sequencer taking a completed word, and a host byte arriving while that word is still pending. The bench provokes this by writing a third byte on the clock right after the second byte of a header word. It then judges three things at the ports: the overrun bit must rise, the rest of the load must write exactly the expected halves at the expected addresses, and the branch target must be correct. A second overlap is a `start` pulse during a running boot. The bench shows it is ignored because the boot ends with the boot target and a single `done`.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_COUNT,
        ST_STATUS,
        ST_LOWER,
        ST_UPPER,
        ST_FINISH
    } hbl_state_e;
endpackage

// File: rtl/hbl_word_asm.sv
module hbl_word_asm #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [BW-1:0]   byte_i,
    input  logic            open_i,
    input  logic            take_i,
    output logic [2*BW-1:0] word_o,
    output logic            vld_o,
    output logic            rdy_o,
    output logic            ovr_o
);
    logic            have_lo_q;
    logic [BW-1:0]   lo_q;
    logic [2*BW-1:0] word_q;
    logic            vld_q;
    logic            ovr_q;
    logic            accept;

    assign accept = open_i && !vld_q;
    assign rdy_o  = open_i && !have_lo_q && !vld_q;
    assign word_o = word_q;
    assign vld_o  = vld_q;
    assign ovr_o  = ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_lo_q <= 1'b0;
            lo_q      <= '0;
            word_q    <= '0;
            vld_q     <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (take_i) begin
                vld_q <= 1'b0;
            end
            if (wr_i) begin
                if (accept) begin
                    if (!have_lo_q) begin
                        lo_q      <= byte_i;
                        have_lo_q <= 1'b1;
                    end else begin
                        word_q    <= {byte_i, lo_q};
                        vld_q     <= 1'b1;
                        have_lo_q <= 1'b0;
                    end
                end else begin
                    ovr_q <= 1'b1;
                end
            end
        end
    end

    // R8
    rdy_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        have_lo_q |-> !rdy_o);

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !open_i) |=> ovr_q);
endmodule

// File: rtl/hbl_seq.sv
module hbl_seq
    import hbl_pkg::*;
#(
    parameter int          WW        = 16,
    parameter int          AW        = 16,
    parameter int          SW        = 8,
    parameter logic [AW-1:0] BOOT_BASE = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [WW-1:0] reboot_cnt_i,
    input  logic [AW-1:0] reboot_addr_i,
    input  logic [AW-1:0] ret_addr_i,
    input  logic [WW-1:0] word_i,
    input  logic          vld_i,
    output logic          open_o,
    output logic          take_o,
    output logic          iram_we_o,
    output logic          iram_hi_o,
    output logic [AW-1:0] iram_addr_o,
    output logic [WW-1:0] iram_data_o,
    output logic [SW-4:0] cfg_o,
    output logic          wen_o,
    output logic          done_o,
    output logic [AW-1:0] branch_o
);
    localparam int CFG_W = SW - 3;

    hbl_state_e    st_q, st_nxt;
    logic [WW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] tgt_q;
    logic [CFG_W-1:0] cfg_q;
    logic          wen_q;
    logic          we_q, hi_q;
    logic [AW-1:0] wa_q;
    logic [WW-1:0] wd_q;

    assign open_o = (st_q == ST_DUMMY) || (st_q == ST_COUNT) || (st_q == ST_STATUS) ||
                    (st_q == ST_LOWER) || (st_q == ST_UPPER);
    assign take_o = open_o && vld_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (mode_i) st_nxt = (reboot_cnt_i == '0) ? ST_FINISH : ST_LOWER;
                    else        st_nxt = ST_DUMMY;
                end
            end
            ST_DUMMY:  if (vld_i) st_nxt = ST_COUNT;
            ST_COUNT:  if (vld_i) st_nxt = ST_STATUS;
            ST_STATUS: if (vld_i) st_nxt = (cnt_q == '0) ? ST_FINISH : ST_LOWER;
            ST_LOWER:  if (vld_i) st_nxt = ST_UPPER;
            ST_UPPER:  if (vld_i) st_nxt = (cnt_q == WW'(1)) ? ST_FINISH : ST_LOWER;
            ST_FINISH: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            tgt_q  <= '0;
            cfg_q  <= '0;
            wen_q  <= 1'b0;
            we_q   <= 1'b0;
            hi_q   <= 1'b0;
            wa_q   <= '0;
            wd_q   <= '0;
        end else begin
            we_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (mode_i) begin
                            cnt_q  <= reboot_cnt_i;
                            addr_q <= reboot_addr_i;
                            tgt_q  <= ret_addr_i;
                        end else begin
                            addr_q <= BOOT_BASE;
                            tgt_q  <= BOOT_BASE;
                        end
                    end
                end
                ST_COUNT: if (vld_i) cnt_q <= word_i;
                ST_STATUS: begin
                    if (vld_i) begin
                        cfg_q <= word_i[SW-1:3];
                        wen_q <= 1'b1;
                    end
                end
                ST_LOWER: begin
                    if (vld_i) begin
                        we_q <= 1'b1;
                        hi_q <= 1'b0;
                        wa_q <= addr_q;
                        wd_q <= word_i;
                    end
                end
                ST_UPPER: begin
                    if (vld_i) begin
                        we_q   <= 1'b1;
                        hi_q   <= 1'b1;
                        wa_q   <= addr_q;
                        wd_q   <= word_i;
                        addr_q <= addr_q + AW'(1);
                        cnt_q  <= cnt_q - WW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign iram_we_o   = we_q;
    assign iram_hi_o   = hi_q;
    assign iram_addr_o = wa_q;
    assign iram_data_o = wd_q;
    assign cfg_o       = cfg_q;
    assign wen_o       = wen_q;
    assign done_o      = (st_q == ST_FINISH);
    assign branch_o    = tgt_q;

    // R4
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iram_we_o |=> !iram_we_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iram_we_o && iram_hi_o) |-> (st_q != ST_UPPER));

    // R3
    wen_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_o |=> wen_o);
endmodule

// File: rtl/hbl_loader.sv
module hbl_loader #(
    parameter int BW = 8,
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [BW-1:0]   host_byte,
    input  logic            start,
    input  logic            start_mode,
    input  logic [2*BW-1:0] reboot_count,
    input  logic [AW-1:0]   reboot_addr,
    input  logic [AW-1:0]   ret_addr,
    output logic            iram_we,
    output logic            iram_hi,
    output logic [AW-1:0]   iram_addr,
    output logic [2*BW-1:0] iram_data,
    output logic [SW-1:0]   host_status,
    output logic            host_rdy_n,
    output logic            done,
    output logic [AW-1:0]   branch_addr
);
    localparam int WW = 2 * BW;

    logic [WW-1:0] word;
    logic          vld, rdy, ovr, open, take, wen;
    logic [SW-4:0] cfg;

    hbl_word_asm #(.BW(BW)) i_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (host_wr),
        .byte_i (host_byte),
        .open_i (open),
        .take_i (take),
        .word_o (word),
        .vld_o  (vld),
        .rdy_o  (rdy),
        .ovr_o  (ovr)
    );

    hbl_seq #(.WW(WW), .AW(AW), .SW(SW)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .mode_i        (start_mode),
        .reboot_cnt_i  (reboot_count),
        .reboot_addr_i (reboot_addr),
        .ret_addr_i    (ret_addr),
        .word_i        (word),
        .vld_i         (vld),
        .open_o        (open),
        .take_o        (take),
        .iram_we_o     (iram_we),
        .iram_hi_o     (iram_hi),
        .iram_addr_o   (iram_addr),
        .iram_data_o   (iram_data),
        .cfg_o         (cfg),
        .wen_o         (wen),
        .done_o        (done),
        .branch_o      (branch_addr)
    );

    assign host_status = {cfg, wen, ovr, rdy};
    assign host_rdy_n  = ~rdy;

    // R8
    rdy_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rdy_n) |=> host_rdy_n);

    // R9
    ovr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && vld) |=> host_status[1]);
endmodule

// File: tb/test_hbl_loader.sv
`timescale 1ns/1ps
module test_hbl_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_byte = '0;
    logic        start = 1'b0;
    logic        start_mode = 1'b0;
    logic [15:0] reboot_count = '0;
    logic [15:0] reboot_addr = '0;
    logic [15:0] ret_addr = '0;
    logic        iram_we, iram_hi;
    logic [15:0] iram_addr, iram_data;
    logic [7:0]  host_status;
    logic        host_rdy_n, done;
    logic [15:0] branch_addr;

    hbl_loader i_hbl_loader (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_byte(host_byte),
        .start(start), .start_mode(start_mode), .reboot_count(reboot_count),
        .reboot_addr(reboot_addr), .ret_addr(ret_addr), .iram_we(iram_we),
        .iram_hi(iram_hi), .iram_addr(iram_addr), .iram_data(iram_data),
        .host_status(host_status), .host_rdy_n(host_rdy_n), .done(done),
        .branch_addr(branch_addr)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [15:0] log_addr [0:63];
    logic        log_hi   [0:63];
    logic [15:0] log_data [0:63];
    int          nlog = 0;
    int          ndone = 0;
    logic [15:0] last_branch = '0;
    logic [31:0] ins [0:15];
    logic        exp_ovr = 1'b0;
    logic [5:0]  exp_st72 = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (iram_we) begin
                if (nlog < 64) begin
                    log_addr[nlog] = iram_addr;
                    log_hi[nlog]   = iram_hi;
                    log_data[nlog] = iram_data;
                end
                nlog++;
            end
            if (done) begin
                ndone++;
                last_branch = branch_addr;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_rdy();
        int t = 0;
        while (host_rdy_n && t < 1000) begin
            @(negedge clk);
            t++;
        end
        if (host_rdy_n) chk(1'b0, "R8", "ready never returned", 0, 1);
    endtask

    task automatic raw_byte(input logic [7:0] b);
        host_wr = 1'b1;
        host_byte = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic put_word(input logic [15:0] w);
        wait_rdy();
        raw_byte(w[7:0]);
        raw_byte(w[15:8]);
    endtask

    task automatic pulse_start(input logic m);
        start_mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (ndone == 0 && t < 200) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_log(input int n, input logic [15:0] base, input string req);
        chk(nlog == 2 * n, "R4", {req, " write count"}, nlog, 2 * n);
        for (int i = 0; i < n && 2 * i + 1 < 64 && 2 * i + 1 < nlog; i++) begin
            chk(log_addr[2*i] == base + 16'(i) && log_addr[2*i+1] == base + 16'(i),
                "R5", {req, " address"}, log_addr[2*i+1], base + 16'(i));
            chk(!log_hi[2*i] && log_hi[2*i+1], "R4", {req, " half order"},
                {log_hi[2*i], log_hi[2*i+1]}, 2'b01);
            chk({log_data[2*i+1], log_data[2*i]} == ins[i], "R1", {req, " instruction data"},
                {log_data[2*i+1], log_data[2*i]}, ins[i]);
        end
    endtask

    // variant: 0 plain, 1 ready timing probe, 2 overrun injection, 3 start while busy
    task automatic do_boot(input int n, input logic [15:0] sw, input logic [15:0] dummy,
                           input int variant);
        nlog = 0;
        ndone = 0;
        for (int i = 0; i < n; i++) ins[i] = $urandom;
        pulse_start(1'b0);
        if (variant == 1) begin
            chk(host_rdy_n == 1'b0 && host_status[0], "R8", "ready while waiting", host_rdy_n, 0);
            host_wr = 1'b1; host_byte = dummy[7:0];
            @(negedge clk);
            chk(host_rdy_n == 1'b1 && !host_status[0], "R8", "ready after first byte", host_rdy_n, 1);
            host_byte = dummy[15:8];
            @(negedge clk);
            host_wr = 1'b0;
            chk(host_rdy_n == 1'b1, "R8", "ready while word pending", host_rdy_n, 1);
            @(negedge clk);
            chk(host_rdy_n == 1'b0, "R8", "ready one clock after take", host_rdy_n, 0);
        end else if (variant == 2) begin
            wait_rdy();
            raw_byte(dummy[7:0]);
            raw_byte(dummy[15:8]);
            raw_byte(8'hA5);
            exp_ovr = 1'b1;
            chk(host_status[1] == 1'b1, "R9", "overrun on pending word", host_status[1], 1);
        end else begin
            put_word(dummy);
        end
        if (variant == 3) begin
            reboot_count = 16'd0;
            ret_addr = 16'h7777;
            pulse_start(1'b1);
        end
        put_word(16'(n));
        put_word(sw);
        for (int i = 0; i < n; i++) begin
            put_word(ins[i][15:0]);
            put_word(ins[i][31:16]);
        end
        wait_done();
        exp_st72 = {sw[7:3], 1'b1};
        chk(ndone == 1, "R6", "boot done pulses", ndone, 1);
        chk(last_branch == 16'h0200, (variant == 3) ? "R11" : "R6", "boot branch",
            last_branch, 16'h0200);
        check_log(n, 16'h0200, (n == 0) ? "R10" : "R2");
        chk(host_status[7:2] == exp_st72, "R3", "status setting", host_status[7:2], exp_st72);
        chk(host_status[1] == exp_ovr, "R9", "overrun bit", host_status[1], exp_ovr);
        chk(host_status[0] == 1'b0 && host_rdy_n, "R8", "idle not ready", host_status[0], 0);
    endtask

    task automatic do_reboot(input int n, input logic [15:0] base, input logic [15:0] ret);
        nlog = 0;
        ndone = 0;
        for (int i = 0; i < n; i++) ins[i] = $urandom;
        reboot_count = 16'(n);
        reboot_addr = base;
        ret_addr = ret;
        pulse_start(1'b1);
        for (int i = 0; i < n; i++) begin
            put_word(ins[i][15:0]);
            put_word(ins[i][31:16]);
        end
        wait_done();
        chk(ndone == 1, "R6", "reboot done pulses", ndone, 1);
        chk(last_branch == ret, "R6", "reboot branch", last_branch, ret);
        check_log(n, base, (n == 0) ? "R10" : "R7");
        chk(host_status[7:2] == exp_st72, "R3", "reboot keeps status", host_status[7:2], exp_st72);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(host_status == 8'h00, "R12", "reset status", host_status, 0);
        chk(host_rdy_n == 1'b1, "R12", "reset ready pin", host_rdy_n, 1);
        chk(!iram_we && !done, "R12", "reset strobes", {iram_we, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_boot(0, 16'h00F8, 16'h0000, 1);      // R10 zero count, R8 timing
        do_boot(3, 16'h0053, 16'hBEEF, 0);      // R2 filler value ignored, R3 bit 2 forced
        raw_byte(8'h3C);                         // R9 byte while idle
        exp_ovr = 1'b1;
        chk(host_status[1] == 1'b1, "R9", "overrun on idle byte", host_status[1], 1);
        chk(ndone == 1 && !iram_we, "R9", "idle byte no effect", iram_we, 0);
        do_boot(2, 16'h00A8, 16'h0000, 2);      // R9 overrun during take
        do_boot(2, 16'h0010, 16'h0000, 3);      // R11 start while busy
        do_reboot(0, 16'h4000, 16'h1234);       // R10
        do_reboot(4, 16'hBFFB, 16'h0321);       // R7 top of region

        for (int k = 0; k < 16; k++) begin
            int n = $urandom_range(0, 8);
            if ($urandom_range(0, 1) == 0)
                do_boot(n, 16'($urandom), 16'($urandom), 0);
            else
                do_reboot(n, 16'h4000 + 16'($urandom_range(0, 16'h7FF0)), 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule